// File: doc/BRIEF.md
# Memory-Mapped Performance Counter Unit

This block counts hardware events for software profiling. A bank of event counters, each steered by a small type selector to one line of an event-pulse vector, sits beside an optional free-running cycle counter. All state is reached through a 32-bit register port that takes one access per clock: address, write data, a write strobe, and read data that follows the address in the same cycle. Software preloads counters, for example to half their range so it has time to respond before a wrap. It enables individual counters and interrupts, starts and stops the whole bank from one control register, and acknowledges wraps through a sticky overflow status.

Per-counter enable, interrupt enable and overflow status each sit behind a pair of set and clear words. Counter index i uses bit i, and the cycle counter uses bit 31. A read-only configuration word reports the counter count, the counter width and whether a cycle counter is present. Counters wider than 32 bits take two words of address space.

Top module: `pmu_counter_unit`

## Requirements
- R1: The configuration word at 0xE00 is read-only and reads as counters−1 in bits 7:0, counter width−1 in bits 13:8, and cycle-counter presence in bit 14. All other bits read 0.
- R2: After reset, every counter, enable bit, interrupt-enable bit, overflow bit and the control word read 0, and `irq` is low.
- R3: Event counter i increases by exactly one on each clock edge at which the event line chosen by its type word is high, control bit 0 (run) is 1, and bit i of the count-enable state is 1. No other combination changes it.
- R4: The count-enable pair (set 0xC00, clear 0xC20) and the interrupt-enable pair (set 0xC40, clear 0xC60) work the same way. A 1 in a written bit sets or clears that bit, a 0 leaves it unchanged, and both addresses of a pair read the current state. Bits that belong to no counter always read 0.
- R5: Software writes load counters. With a width above 32, counter n is at 8·n (bits 31:0) and 8·n+4 (upper bits, zero-extended on read), and each half can be written alone. With a width of 32 or less, counter n is at 4·n.
- R6: A counter that steps from all ones to zero sets its overflow bit. The bit stays set until a 1 is written to it at 0xC80. Writing 1 at 0xCC0 also sets it, and both addresses read the status.
- R7: `irq` is high exactly when some counter has both its overflow bit and its interrupt-enable bit set.
- R8: The control word is at 0xE04. Bit 0 is the run bit and reads back. Writing bit 1 zeroes all event counters, and writing bit 2 zeroes the cycle counter. Bits 1 and 2 always read 0. Writing 0 stops all counting.
- R9: The cycle counter uses physical index 31. It counts every clock while the run bit and count-enable bit 31 are set. It sits at counter slot 31 (0x0F8/0x0FC for wide counters), and its filter word is at 0x47C.
- R10: The type word of counter n at 0x400+4·n keeps the low log2(events) bits. The filter word at 0xA00+4·n keeps all 32 bits. Reads of offsets that hold no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_in | input | NUM_EVT | Event pulse lines, counted while high at a clock edge |
| irq | output | 1 | Level overflow interrupt |

## Verification
The case that is hardest to reach from the ports is the wrap from all ones to zero. Counting there from reset would take 2^40 events. The stimulus reaches it by preloading each half of the counter separately through the wide two-word layout and then giving one pulse, which sets the sticky flag in a chosen cycle. The same preload drives the cycle counter across its wrap, so bit 31 of the status word is exercised. The count path is swept over every type selection crossed with every event line and two enable masks. The bench keeps its own arithmetic count for each counter.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   // Register map offsets (byte addresses)
   localparam logic [11:0] OFS_TYPE      = 12'h400;
   localparam logic [11:0] OFS_CYC_FILT  = 12'h47C;
   localparam logic [11:0] OFS_FILT      = 12'hA00;
   localparam logic [11:0] OFS_CNTEN_SET = 12'hC00;
   localparam logic [11:0] OFS_CNTEN_CLR = 12'hC20;
   localparam logic [11:0] OFS_INTEN_SET = 12'hC40;
   localparam logic [11:0] OFS_INTEN_CLR = 12'hC60;
   localparam logic [11:0] OFS_OVF_CLR   = 12'hC80;
   localparam logic [11:0] OFS_OVF_SET   = 12'hCC0;
   localparam logic [11:0] OFS_CFG       = 12'hE00;
   localparam logic [11:0] OFS_CTRL      = 12'hE04;

   // Physical index of the cycle counter in the set/clear words
   localparam int CYC_IDX = 31;

   // Control word bit positions
   localparam int CTRL_RUN     = 0;
   localparam int CTRL_EV_ZERO = 1;
   localparam int CTRL_CY_ZERO = 2;
endpackage

// File: rtl/pmu_ctr_cell.sv
module pmu_ctr_cell #(
   parameter int W = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic         ld_lo,
   input  logic         ld_hi,
   input  logic [31:0]  wdata,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   logic [W-1:0] ld_val;

   generate
      if (W < 1 || W > 64) begin : g_bad_w
         $error("pmu_ctr_cell: W must be 1..64");
      end
      if (W > 32) begin : g_wide
         assign ld_val = {ld_hi ? wdata[W-33:0] : cnt[W-1:32],
                          ld_lo ? wdata        : cnt[31:0]};
      end else begin : g_narrow
         logic unused_hi;
         assign unused_hi = ld_hi;
         assign ld_val    = wdata[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (ld_lo || ld_hi) cnt <= ld_val;
      else if (inc)            cnt <= cnt + 1'b1;
   end

   assign wrap = inc && !clr && !ld_lo && !ld_hi && (&cnt);

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0)); // R6
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0)); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc && !ld_lo && !ld_hi) |=> $stable(cnt)); // R3
endmodule

// File: rtl/pmu_setclr.sv
module pmu_setclr #(
   parameter int          W    = 32,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   logic [W-1:0] set_bits, clr_bits;

   assign set_bits = set_we ? wdata : '0;
   assign clr_bits = clr_we ? wdata : '0;

   // A hardware set in the same cycle as a software clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (((q | set_bits) & ~clr_bits) | hw_set) & MASK;
   end

   AST_WRITE0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we && hw_set == '0) |=> $stable(q)); // R4
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((q & $past(q)) == $past(q))); // R6
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit #(
   parameter int NUM_CTR = 4,
   parameter int CTR_W   = 40,
   parameter int NUM_EVT = 8,
   parameter int HAS_CYC = 1,
   parameter int AW      = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      bus_addr,
   input  logic [31:0]        bus_wdata,
   input  logic               bus_we,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_EVT-1:0] evt_in,
   output logic               irq
);
   import pmu_pkg::*;

   localparam int          SEL_W  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
   localparam bit          WIDE   = (CTR_W > 32);
   localparam int          STRIDE = WIDE ? 8 : 4;
   localparam logic [31:0] IMPL_MASK = ((HAS_CYC != 0) ? (32'd1 << CYC_IDX) : 32'd0)
                                     | ((32'd1 << NUM_CTR) - 32'd1);
   localparam logic [31:0] CFG_WORD = {17'd0, (HAS_CYC != 0), 6'(CTR_W - 1), 8'(NUM_CTR - 1)};

   generate
      if (NUM_CTR < 1 || NUM_CTR > 31) begin : g_bad_n
         $error("pmu_counter_unit: NUM_CTR must be 1..31");
      end
      if (NUM_EVT < 2 || (NUM_EVT & (NUM_EVT - 1)) != 0) begin : g_bad_evt
         $error("pmu_counter_unit: NUM_EVT must be a power of two >= 2");
      end
      if (CTR_W < 1 || CTR_W > 64) begin : g_bad_w
         $error("pmu_counter_unit: CTR_W must be 1..64");
      end
      if (AW < 12) begin : g_bad_aw
         $error("pmu_counter_unit: AW must be at least 12");
      end
   endgenerate

   // ---------------- global control ----------------
   logic ctrl_wr, ctrl_run, ev_zero, cy_zero;
   assign ctrl_wr = bus_we && (bus_addr == AW'(OFS_CTRL));
   assign ev_zero = ctrl_wr && bus_wdata[CTRL_EV_ZERO];
   assign cy_zero = ctrl_wr && bus_wdata[CTRL_CY_ZERO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_run <= 1'b0;
      else if (ctrl_wr) ctrl_run <= bus_wdata[CTRL_RUN];
   end

   // ---------------- set/clear state words ----------------
   logic [31:0] cnten, inten, ovf, ovf_hw;
   logic [NUM_CTR-1:0] ev_wrap;
   logic cyc_wrap;

   always_comb begin
      ovf_hw                = '0;
      ovf_hw[NUM_CTR-1:0]   = ev_wrap;
      ovf_hw[CYC_IDX]       = cyc_wrap;
   end

   pmu_setclr #(.W(32), .MASK(IMPL_MASK)) u_cnten (
      .clk, .rst_n,
      .set_we (bus_we && bus_addr == AW'(OFS_CNTEN_SET)),
      .clr_we (bus_we && bus_addr == AW'(OFS_CNTEN_CLR)),
      .wdata  (bus_wdata), .hw_set ('0), .q (cnten));

   pmu_setclr #(.W(32), .MASK(IMPL_MASK)) u_inten (
      .clk, .rst_n,
      .set_we (bus_we && bus_addr == AW'(OFS_INTEN_SET)),
      .clr_we (bus_we && bus_addr == AW'(OFS_INTEN_CLR)),
      .wdata  (bus_wdata), .hw_set ('0), .q (inten));

   pmu_setclr #(.W(32), .MASK(IMPL_MASK)) u_ovf (
      .clk, .rst_n,
      .set_we (bus_we && bus_addr == AW'(OFS_OVF_SET)),
      .clr_we (bus_we && bus_addr == AW'(OFS_OVF_CLR)),
      .wdata  (bus_wdata), .hw_set (ovf_hw), .q (ovf));

   assign irq = |(ovf & inten);

   // ---------------- event counters ----------------
   logic [63:0]      ev_ext   [NUM_CTR];
   logic [SEL_W-1:0] sel_arr  [NUM_CTR];
   logic [31:0]      filt_arr [NUM_CTR];

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      logic [SEL_W-1:0] sel_q;
      logic [31:0]      filt_q;
      logic [CTR_W-1:0] cnt;
      logic             inc, ld_lo, ld_hi;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_q  <= '0;
            filt_q <= '0;
         end else if (bus_we) begin
            if (bus_addr == AW'(OFS_TYPE + 12'(4 * i))) sel_q  <= bus_wdata[SEL_W-1:0];
            if (bus_addr == AW'(OFS_FILT + 12'(4 * i))) filt_q <= bus_wdata;
         end
      end

      assign inc   = ctrl_run && cnten[i] && evt_in[sel_q];
      assign ld_lo = bus_we && (bus_addr == AW'(STRIDE * i));
      assign ld_hi = WIDE && bus_we && (bus_addr == AW'(STRIDE * i + 4));

      pmu_ctr_cell #(.W(CTR_W)) u_cell (
         .clk, .rst_n, .clr (ev_zero), .inc, .ld_lo, .ld_hi,
         .wdata (bus_wdata), .cnt, .wrap (ev_wrap[i]));

      assign ev_ext[i]   = 64'(cnt);
      assign sel_arr[i]  = sel_q;
      assign filt_arr[i] = filt_q;
   end

   // ---------------- cycle counter ----------------
   logic [63:0] cyc_ext;
   logic [31:0] cyc_filt;

   generate
      if (HAS_CYC != 0) begin : g_cyc
         logic [CTR_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cyc_filt <= '0;
            else if (bus_we && bus_addr == AW'(OFS_CYC_FILT)) cyc_filt <= bus_wdata;
         end
         pmu_ctr_cell #(.W(CTR_W)) u_cell (
            .clk, .rst_n, .clr (cy_zero),
            .inc   (ctrl_run && cnten[CYC_IDX]),
            .ld_lo (bus_we && bus_addr == AW'(STRIDE * CYC_IDX)),
            .ld_hi (WIDE && bus_we && bus_addr == AW'(STRIDE * CYC_IDX + 4)),
            .wdata (bus_wdata), .cnt, .wrap (cyc_wrap));
         assign cyc_ext = 64'(cnt);
      end else begin : g_no_cyc
         assign cyc_ext  = '0;
         assign cyc_filt = '0;
         assign cyc_wrap = 1'b0;
      end
   endgenerate

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < NUM_CTR; k++) begin
         if (bus_addr == AW'(STRIDE * k))                 bus_rdata = ev_ext[k][31:0];
         if (WIDE && bus_addr == AW'(STRIDE * k + 4))     bus_rdata = ev_ext[k][63:32];
         if (bus_addr == AW'(OFS_TYPE + 12'(4 * k)))      bus_rdata = 32'(sel_arr[k]);
         if (bus_addr == AW'(OFS_FILT + 12'(4 * k)))      bus_rdata = filt_arr[k];
      end
      if (HAS_CYC != 0) begin
         if (bus_addr == AW'(STRIDE * CYC_IDX))             bus_rdata = cyc_ext[31:0];
         if (WIDE && bus_addr == AW'(STRIDE * CYC_IDX + 4)) bus_rdata = cyc_ext[63:32];
         if (bus_addr == AW'(OFS_CYC_FILT))                 bus_rdata = cyc_filt;
      end
      if (bus_addr == AW'(OFS_CNTEN_SET) || bus_addr == AW'(OFS_CNTEN_CLR)) bus_rdata = cnten;
      if (bus_addr == AW'(OFS_INTEN_SET) || bus_addr == AW'(OFS_INTEN_CLR)) bus_rdata = inten;
      if (bus_addr == AW'(OFS_OVF_SET)   || bus_addr == AW'(OFS_OVF_CLR))   bus_rdata = ovf;
      if (bus_addr == AW'(OFS_CFG))  bus_rdata = CFG_WORD;
      if (bus_addr == AW'(OFS_CTRL)) bus_rdata = {31'd0, ctrl_run};
   end

   AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ovf != '0)); // R7
   AST_CTRL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == AW'(OFS_CTRL)) |-> (bus_rdata[2:1] == 2'b00)); // R8
endmodule

// File: tb/pmu_counter_unit_tb.sv
module pmu_counter_unit_tb;
   localparam int NC = 4;
   localparam int NE = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [NE-1:0] evt_in = '0;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   pmu_counter_unit #(.NUM_CTR(NC), .CTR_W(40), .NUM_EVT(NE), .HAS_CYC(1), .AW(12)) u_dut (
      .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_rdata, .evt_in, .irq);

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=0x%08h expected=0x%08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_we = 1'b0;
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse(input logic [NE-1:0] m);
      @(negedge clk);
      evt_in = m;
      @(negedge clk);
      evt_in = '0;
   endtask

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog got=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      int exp_cnt [NC];
      int typ [NC];
      logic [NC-1:0] en;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      rd(12'h000, d); check("R2 ctr0 lo", d, 32'h0);
      rd(12'h01C, d); check("R2 ctr3 hi", d, 32'h0);
      rd(12'h0F8, d); check("R2 cyc lo", d, 32'h0);
      rd(12'hC00, d); check("R2 cnten", d, 32'h0);
      rd(12'hC80, d); check("R2 ovf", d, 32'h0);
      rd(12'hE04, d); check("R2 ctrl", d, 32'h0);
      check("R2 irq", {31'd0, irq}, 32'h0);

      // R1 configuration word: 3 | (39<<8) | (1<<14)
      rd(12'hE00, d); check("R1 cfg", d, 32'h0000_6703);
      wr(12'hE00, 32'hFFFF_FFFF);
      rd(12'hE00, d); check("R1 cfg read-only", d, 32'h0000_6703);

      // R10 type/filter storage, unused offsets
      wr(12'h400, 32'hFF);
      rd(12'h400, d); check("R10 type masked", d, 32'h7);
      wr(12'hA04, 32'hDEAD_BEEF);
      rd(12'hA04, d); check("R10 filter", d, 32'hDEAD_BEEF);
      rd(12'hA10, d); check("R10 filter beyond N", d, 32'h0);
      rd(12'h300, d); check("R10 hole", d, 32'h0);
      rd(12'h020, d); check("R10 ctr beyond N", d, 32'h0);

      // R4 set/clear pairs
      wr(12'hC00, 32'h8000_0005);
      rd(12'hC20, d); check("R4 cnten via clr addr", d, 32'h8000_0005);
      wr(12'hC00, 32'h0000_0010);
      rd(12'hC00, d); check("R4 unimplemented bit", d, 32'h8000_0005);
      wr(12'hC20, 32'h0000_0001);
      rd(12'hC00, d); check("R4 clear one bit", d, 32'h8000_0004);
      wr(12'hC20, 32'h0);
      rd(12'hC00, d); check("R4 write zero keeps", d, 32'h8000_0004);
      wr(12'hC20, 32'hFFFF_FFFF);
      wr(12'hC40, 32'h0000_0003);
      rd(12'hC60, d); check("R4 inten set", d, 32'h0000_0003);
      wr(12'hC60, 32'hFFFF_FFFF);
      rd(12'hC40, d); check("R4 inten clear", d, 32'h0);

      // R3 sweep: every selection crossed with every line, two enable masks
      wr(12'hE04, 32'h2);
      for (int k = 0; k < NC; k++) exp_cnt[k] = 0;
      wr(12'hE04, 32'h1);
      for (int s = 0; s < NE; s++) begin
         en = (s % 2 == 1) ? 4'hF : 4'h5;
         wr(12'hC20, 32'hF);
         wr(12'hC00, 32'(en));
         for (int k = 0; k < NC; k++) begin
            typ[k] = (s + k) % NE;
            wr(12'h400 + 12'(4 * k), 32'(typ[k]));
         end
         for (int e = 0; e < NE; e++) begin
            pulse(NE'(1) << e);
            for (int k = 0; k < NC; k++) begin
               if (en[k] && typ[k] == e) exp_cnt[k]++;
               rd(12'(8 * k), d);
               check("R3 sweep count", d, 32'(exp_cnt[k]));
            end
         end
      end

      // R8 run bit cleared stops counting
      wr(12'hE04, 32'h0);
      pulse('1);
      for (int k = 0; k < NC; k++) begin
         rd(12'(8 * k), d); check("R8 stopped", d, 32'(exp_cnt[k]));
      end

      // R5 preload, split halves
      wr(12'h008, 32'h0000_0010);
      wr(12'h00C, 32'h0000_00AB);
      rd(12'h008, d); check("R5 lo half", d, 32'h10);
      rd(12'h00C, d); check("R5 hi half", d, 32'hAB);
      wr(12'h00C, 32'h0000_01FF);
      rd(12'h00C, d); check("R5 hi truncated", d, 32'hFF);
      rd(12'h008, d); check("R5 lo untouched", d, 32'h10);

      // R6 / R7 wrap, sticky status, interrupt
      wr(12'hC20, 32'hFFFF_FFFF);
      wr(12'h408, 32'h0);
      wr(12'h010, 32'hFFFF_FFFF);
      wr(12'h014, 32'h0000_00FF);
      wr(12'hC00, 32'h4);
      wr(12'hE04, 32'h1);
      pulse(8'h01);
      rd(12'h010, d); check("R6 wrapped lo", d, 32'h0);
      rd(12'h014, d); check("R6 wrapped hi", d, 32'h0);
      rd(12'hC80, d); check("R6 ovf set", d, 32'h4);
      rd(12'hCC0, d); check("R6 ovf via set addr", d, 32'h4);
      check("R7 irq masked", {31'd0, irq}, 32'h0);
      wr(12'hC40, 32'h4);
      check("R7 irq raised", {31'd0, irq}, 32'h1);
      wr(12'hC80, 32'h0);
      rd(12'hC80, d); check("R6 write zero keeps", d, 32'h4);
      check("R7 irq held", {31'd0, irq}, 32'h1);
      wr(12'hC80, 32'h4);
      rd(12'hC80, d); check("R6 ack", d, 32'h0);
      check("R7 irq dropped", {31'd0, irq}, 32'h0);
      wr(12'hCC0, 32'h2);
      rd(12'hC80, d); check("R6 software set", d, 32'h2);
      check("R7 other bit masked", {31'd0, irq}, 32'h0);
      wr(12'hC40, 32'h2);
      check("R7 second source", {31'd0, irq}, 32'h1);
      wr(12'hC60, 32'h2);
      check("R7 inten cleared", {31'd0, irq}, 32'h0);
      rd(12'hC40, d); check("R4 inten after clear", d, 32'h4);
      wr(12'hC80, 32'hFFFF_FFFF);
      wr(12'hC60, 32'hFFFF_FFFF);
      wr(12'hE04, 32'h0);
      wr(12'hC20, 32'hFFFF_FFFF);

      // R9 cycle counter: 12 counting edges expected
      wr(12'hE04, 32'h4);
      rd(12'h0F8, d); check("R9 cyc zeroed", d, 32'h0);
      wr(12'hC00, 32'h8000_0000);
      wr(12'hE04, 32'h1);
      repeat (10) @(negedge clk);
      wr(12'hE04, 32'h0);
      rd(12'h0F8, d); check("R9 cyc count", d, 32'd12);
      repeat (5) @(negedge clk);
      rd(12'h0F8, d); check("R8 cyc stopped", d, 32'd12);
      rd(12'h008, d); check("R9 event ctr untouched", d, 32'h10);
      wr(12'h47C, 32'h1234_5678);
      rd(12'h47C, d); check("R9 cyc filter", d, 32'h1234_5678);

      // R8 selective resets and self-clearing bits
      wr(12'hE04, 32'h4);
      rd(12'h0F8, d); check("R8 cyc reset", d, 32'h0);
      rd(12'h008, d); check("R8 event kept on cyc reset", d, 32'h10);
      wr(12'hE04, 32'h2);
      rd(12'h008, d); check("R8 event reset lo", d, 32'h0);
      rd(12'h00C, d); check("R8 event reset hi", d, 32'h0);
      wr(12'hE04, 32'h7);
      rd(12'hE04, d); check("R8 ctrl readback", d, 32'h1);
      wr(12'hE04, 32'h0);

      // R9 / R6 cycle counter wrap on bit 31
      wr(12'hC80, 32'hFFFF_FFFF);
      wr(12'h0F8, 32'hFFFF_FFFF);
      wr(12'h0FC, 32'h0000_00FF);
      wr(12'hE04, 32'h1);
      wr(12'hE04, 32'h0);
      rd(12'hC80, d); check("R9 cyc overflow bit31", d & 32'h8000_0000, 32'h8000_0000);
      rd(12'h0FC, d); check("R9 cyc hi after wrap", d, 32'h0);

      summary();
      $finish;
   end
endmodule